// File: doc/BRIEF.md
# Six-Channel Converter Result and Control Register Bank

This block keeps the conversion results of a six-channel converter front end together with five control and status words, and lets a byte-wide host port read and write them. The modulator side hands over all six 24-bit results at once with a data-ready strobe. The host opens a transaction by giving a start address and a direction, moves one byte per request, and closes the transaction with a stop pulse.

Bytes of a word leave the block most significant byte first. The address counter moves after the last byte of each word. How far it moves depends on a 2-bit loop mode stored in the status/communication word. The loop can stay on one register, circle a small group, circle one bank, or circle the whole map.

A word is captured whole when its first byte is requested. A data-ready strobe that arrives between the bytes of a word therefore changes only later words. A strobe that lands in the same cycle as a first-byte request hands its new sample straight to the host.

Top module: `adc_regbank`

## Requirements
- R1: The map has eleven 24-bit words. Addresses 0..5 are the channel 0..5 results and are read-only. Addresses 6..10 are read/write control words: modulator value, phase, gain, status/communication and configuration. After reset the control words and the read byte are zero.
- R2: A data-ready strobe loads all six results from dr_data in one cycle. Channel c occupies bits [24c+23:24c]. No result ever shows a mix of two samples.
- R3: The whole word is captured on the first byte request of a register. A strobe that arrives before the second or third byte of that word does not change those bytes. The new sample appears at the next read of that register.
- R4: When a strobe and a first-byte read request fall in the same cycle, the word returned is the sample carried by that strobe.
- R5: Read bytes come out in the order bits [23:16], [15:8], [7:0]. Each byte is valid on hst_rdata in the cycle after its request.
- R6: A write sends three bytes, most significant first. The word is committed on the third byte, and only when the address is 6..10. Writes to addresses 0..5 or above 10 leave every register unchanged.
- R7: A read of any address above 10 returns zero bytes, and the address counter stays where it is.
- R8: The loop mode is held in bits [23:22] of the word at address 9. Mode 0 re-reads the same address after every word.
- R9: Mode 1 alternates within the channel pairs {0,1}, {2,3} and {4,5}, and steps through 6..10 wrapping to 6.
- R10: Mode 2 steps through 0..5 wrapping to 0, or through 6..10 wrapping to 6.
- R11: Mode 3 steps through 0..10 and wraps from 10 back to 0.
- R12: Byte requests outside a transaction, that is before a start or after a stop, change neither the read byte nor the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dr_strobe | input | 1 | Data-ready pulse from the modulator side |
| dr_data | input | 144 | Six new 24-bit results, channel c at bits [24c+23:24c] |
| hst_start | input | 1 | Opens a transaction; samples hst_addr and hst_rw |
| hst_stop | input | 1 | Closes the transaction |
| hst_rw | input | 1 | 1 = write transaction, 0 = read |
| hst_addr | input | 5 | Start address of the transaction |
| hst_byte_req | input | 1 | Request to move one byte |
| hst_wdata | input | 8 | Write byte |
| hst_rdata | output | 8 | Read byte, registered |

## Verification
Assertions watch the properties that hold on every cycle. Results stay untouched except in strobe cycles. Control words change only on a committed write, and a commit never targets a result or an unmapped address. Out-of-map reads give zero. The address counter holds outside transactions and after a word in mode 0, stays inside its pair or bank in modes 1 and 2, and never leaves the map. Only the bench scenarios show the exact loop orders, including the wrap points, the word-level capture when a strobe arrives mid-word, the same-cycle bypass, and read-back of written control words.

// File: rtl/adc_rb_pkg.sv
package adc_rb_pkg;

  localparam int WORD_W    = 24;
  localparam int BYTE_W    = 8;
  localparam int ADDR_W    = 5;
  localparam int NUM_CH    = 6;
  localparam int NUM_CTRL  = 5;
  localparam int STAT_IDX  = 3;   // status/communication word, address NUM_CH+3
  localparam int BYTES_PER_WORD = WORD_W / BYTE_W;

  typedef enum logic [1:0] {
    RM_SAME = 2'd0,
    RM_PAIR = 2'd1,
    RM_BANK = 2'd2,
    RM_ALL  = 2'd3
  } rd_mode_e;

  // Address that follows the last byte of a word.
  function automatic logic [ADDR_W-1:0] next_addr(rd_mode_e mode, logic [ADDR_W-1:0] a,
                                                  int n_ch, int last);
    int ai;
    int r;
    bit in_ch;
    ai    = int'(a);
    in_ch = ai < n_ch;
    r     = ai;
    if (ai <= last) begin
      case (mode)
        RM_SAME: r = ai;
        RM_PAIR: begin
          if (in_ch) r = ai ^ 1;
          else       r = (ai == last) ? n_ch : ai + 1;
        end
        RM_BANK: begin
          if (in_ch) r = (ai == n_ch - 1) ? 0 : ai + 1;
          else       r = (ai == last) ? n_ch : ai + 1;
        end
        default:     r = (ai == last) ? 0 : ai + 1;
      endcase
    end
    return ADDR_W'(r);
  endfunction

endpackage

// File: rtl/adc_rb_results.sv
module adc_rb_results
  import adc_rb_pkg::*;
#(
  parameter int N_CH = NUM_CH,
  parameter int W    = WORD_W,
  localparam int IW  = (N_CH > 1) ? $clog2(N_CH) + 1 : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            dr_strobe,
  input  logic [N_CH*W-1:0] dr_data,
  input  logic [IW-1:0]   rd_idx,
  output logic [W-1:0]    rd_word
);

  logic [W-1:0]      live [N_CH];
  logic [N_CH*W-1:0] live_flat;

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         live[c] <= '0;
      else if (dr_strobe) live[c] <= dr_data[c*W +: W];
    end
    assign live_flat[c*W +: W] = live[c];
  end

  // A strobe in the same cycle as a capture hands the newest sample through.
  always_comb begin
    rd_word = '0;
    if (int'(rd_idx) < N_CH) begin
      if (dr_strobe) rd_word = dr_data[int'(rd_idx)*W +: W];
      else           rd_word = live[int'(rd_idx)];
    end
  end

  // R2: results change only in strobe cycles
  a_r2_results_only_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !dr_strobe |=> $stable(live_flat));

endmodule

// File: rtl/adc_rb_ctrl.sv
module adc_rb_ctrl
  import adc_rb_pkg::*;
#(
  parameter int N_CTRL = NUM_CTRL,
  parameter int W      = WORD_W,
  parameter int S_IDX  = STAT_IDX,
  localparam int IW    = $clog2(N_CTRL) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [IW-1:0] widx,
  input  logic [W-1:0]  wword,
  input  logic [IW-1:0] ridx,
  output logic [W-1:0]  rword,
  output logic [1:0]    mode
);

  logic [W-1:0]        regs [N_CTRL];
  logic [N_CTRL*W-1:0] ctrl_flat;

  for (genvar k = 0; k < N_CTRL; k++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          regs[k] <= '0;
      else if (we && int'(widx) == k)      regs[k] <= wword;
    end
    assign ctrl_flat[k*W +: W] = regs[k];
  end

  assign rword = (int'(ridx) < N_CTRL) ? regs[int'(ridx)] : '0;
  assign mode  = regs[S_IDX][W-1 -: 2];

  // R6: control words move only on a committed write
  a_r6_ctrl_only_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(ctrl_flat));

endmodule

// File: rtl/adc_rb_seq.sv
module adc_rb_seq
  import adc_rb_pkg::*;
#(
  parameter int W     = WORD_W,
  parameter int BW    = BYTE_W,
  parameter int AW    = ADDR_W,
  parameter int N_CH  = NUM_CH,
  parameter int LAST  = NUM_CH + NUM_CTRL - 1,
  localparam int NB   = W / BW,
  localparam int XW   = $clog2(NB) + 1,
  localparam int WBW  = W - BW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          stop,
  input  logic          rw,
  input  logic [AW-1:0] addr_in,
  input  logic          byte_req,
  input  logic [BW-1:0] wdata,
  input  logic [1:0]    mode,
  input  logic [W-1:0]  rd_word,
  output logic [AW-1:0] cur_addr,
  output logic [BW-1:0] rdata,
  output logic          rd_fire,
  output logic          wr_commit,
  output logic [W-1:0]  wr_word
);

  logic          active_q;
  logic          rw_q;
  logic [AW-1:0] addr_q;
  logic [XW-1:0] idx_q;
  logic [W-1:0]  hold_q;
  logic [WBW-1:0] wbuf_q;
  logic [BW-1:0] rdata_q;

  logic byte_fire;
  logic last_byte;
  logic word_done;
  rd_mode_e mode_e;

  assign mode_e    = rd_mode_e'(mode);
  assign byte_fire = active_q && byte_req && !start && !stop;
  assign last_byte = int'(idx_q) == NB - 1;
  assign word_done = byte_fire && last_byte;
  assign rd_fire   = byte_fire && !rw_q;
  assign wr_commit = word_done && rw_q;
  assign wr_word   = {wbuf_q, wdata};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      rw_q     <= 1'b0;
      addr_q   <= '0;
      idx_q    <= '0;
      hold_q   <= '0;
      wbuf_q   <= '0;
      rdata_q  <= '0;
    end else if (start) begin
      active_q <= 1'b1;
      rw_q     <= rw;
      addr_q   <= addr_in;
      idx_q    <= '0;
    end else if (stop) begin
      active_q <= 1'b0;
      idx_q    <= '0;
    end else if (byte_fire) begin
      if (!rw_q) begin
        if (idx_q == '0) begin
          rdata_q <= rd_word[W-1 -: BW];
          hold_q  <= rd_word << BW;
        end else begin
          rdata_q <= hold_q[W-1 -: BW];
          hold_q  <= hold_q << BW;
        end
      end else begin
        wbuf_q <= (wbuf_q << BW) | WBW'(wdata);
      end
      if (last_byte) begin
        idx_q  <= '0;
        addr_q <= next_addr(mode_e, addr_q, N_CH, LAST);
      end else begin
        idx_q <= idx_q + 1'b1;
      end
    end
  end

  assign cur_addr = addr_q;
  assign rdata    = rdata_q;

  // R12: nothing moves outside a transaction
  a_r12_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!active_q && !start) |=> ($stable(addr_q) && $stable(rdata_q)));
  a_r5_idx_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    int'(idx_q) < NB);
  // R8: repeat mode keeps the address
  a_r8_same_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (word_done && mode_e == RM_SAME) |=> $stable(addr_q));
  // R9: pair mode stays in the pair
  a_r9_pair_stays: assert property (@(posedge clk) disable iff (!rst_n)
    (word_done && mode_e == RM_PAIR && int'(addr_q) < N_CH)
      |=> (addr_q[AW-1:1] == $past(addr_q[AW-1:1])));
  // R10: bank mode stays among the channel results
  a_r10_bank_stays: assert property (@(posedge clk) disable iff (!rst_n)
    (word_done && mode_e == RM_BANK && int'(addr_q) < N_CH) |=> int'(addr_q) < N_CH);
  // R11: the counter never leaves the map once inside it
  a_r11_stays_in_map: assert property (@(posedge clk) disable iff (!rst_n)
    (word_done && int'(addr_q) <= LAST) |=> int'(addr_q) <= LAST);

endmodule

// File: rtl/adc_regbank.sv
module adc_regbank
  import adc_rb_pkg::*;
#(
  parameter int N_CH   = NUM_CH,
  parameter int N_CTRL = NUM_CTRL,
  parameter int W      = WORD_W,
  parameter int BW     = BYTE_W,
  parameter int AW     = ADDR_W,
  localparam int LAST  = N_CH + N_CTRL - 1,
  localparam int CH_IW = $clog2(N_CH) + 1,
  localparam int CT_IW = $clog2(N_CTRL) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dr_strobe,
  input  logic [N_CH*W-1:0] dr_data,
  input  logic              hst_start,
  input  logic              hst_stop,
  input  logic              hst_rw,
  input  logic [AW-1:0]     hst_addr,
  input  logic              hst_byte_req,
  input  logic [BW-1:0]     hst_wdata,
  output logic [BW-1:0]     hst_rdata
);

  logic [AW-1:0]    cur_addr;
  logic [W-1:0]     res_word, ctl_word, sel_word, wr_word;
  logic [1:0]       mode;
  logic             rd_fire, wr_commit, ctrl_we;
  logic             in_ch, in_ctrl;
  logic [CH_IW-1:0] ch_idx;
  logic [CT_IW-1:0] ct_idx;

  assign in_ch   = int'(cur_addr) < N_CH;
  assign in_ctrl = !in_ch && int'(cur_addr) <= LAST;
  assign ch_idx  = in_ch   ? CH_IW'(cur_addr) : CH_IW'(N_CH);
  assign ct_idx  = in_ctrl ? CT_IW'(int'(cur_addr) - N_CH) : CT_IW'(N_CTRL);
  assign ctrl_we = wr_commit && in_ctrl;

  always_comb begin
    if (in_ch)        sel_word = res_word;
    else if (in_ctrl) sel_word = ctl_word;
    else              sel_word = '0;
  end

  adc_rb_results #(.N_CH(N_CH), .W(W)) u_res (
    .clk(clk), .rst_n(rst_n), .dr_strobe(dr_strobe), .dr_data(dr_data),
    .rd_idx(ch_idx), .rd_word(res_word)
  );

  adc_rb_ctrl #(.N_CTRL(N_CTRL), .W(W), .S_IDX(STAT_IDX)) u_ctl (
    .clk(clk), .rst_n(rst_n), .we(ctrl_we), .widx(ct_idx), .wword(wr_word),
    .ridx(ct_idx), .rword(ctl_word), .mode(mode)
  );

  adc_rb_seq #(.W(W), .BW(BW), .AW(AW), .N_CH(N_CH), .LAST(LAST)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(hst_start), .stop(hst_stop), .rw(hst_rw),
    .addr_in(hst_addr), .byte_req(hst_byte_req), .wdata(hst_wdata), .mode(mode),
    .rd_word(sel_word), .cur_addr(cur_addr), .rdata(hst_rdata), .rd_fire(rd_fire),
    .wr_commit(wr_commit), .wr_word(wr_word)
  );

  // R6: a committed write never lands on a result or an unmapped address
  a_r6_write_target_ok: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_we |-> (int'(cur_addr) >= N_CH && int'(cur_addr) <= LAST));
  // R7: unmapped reads give zero and keep the address
  a_r7_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fire && int'(cur_addr) > LAST) |=> (hst_rdata == '0 && $stable(cur_addr)));

endmodule

// File: tb/adc_regbank_tb_top.sv
module adc_regbank_tb_top;

  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         dr_strobe = 1'b0;
  logic [143:0] dr_data = '0;
  logic         hst_start = 1'b0, hst_stop = 1'b0, hst_rw = 1'b0, hst_byte_req = 1'b0;
  logic [4:0]   hst_addr = '0;
  logic [7:0]   hst_wdata = '0;
  logic [7:0]   hst_rdata;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  logic [23:0] ch_val [6];
  logic [23:0] ctl    [5];

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_regbank dut_i (
    .clk(clk), .rst_n(rst_n), .dr_strobe(dr_strobe), .dr_data(dr_data),
    .hst_start(hst_start), .hst_stop(hst_stop), .hst_rw(hst_rw), .hst_addr(hst_addr),
    .hst_byte_req(hst_byte_req), .hst_wdata(hst_wdata), .hst_rdata(hst_rdata)
  );

  // {mode, start, addr word1, word2, word3}
  localparam logic [21:0] VEC [8] = '{
    {2'd1, 5'd1,  5'd0,  5'd1,  5'd0},   // R9 pair
    {2'd1, 5'd4,  5'd5,  5'd4,  5'd5},   // R9 pair
    {2'd1, 5'd10, 5'd6,  5'd7,  5'd8},   // R9 control group wrap
    {2'd2, 5'd5,  5'd0,  5'd1,  5'd2},   // R10 channel bank wrap
    {2'd2, 5'd9,  5'd10, 5'd6,  5'd7},   // R10 control bank wrap
    {2'd3, 5'd9,  5'd10, 5'd0,  5'd1},   // R11 full wrap
    {2'd0, 5'd3,  5'd3,  5'd3,  5'd3},   // R8 repeat
    {2'd3, 5'd12, 5'd12, 5'd12, 5'd12}   // R7 unmapped holds
  };

  function automatic logic [23:0] gen_val(int c, int g);
    return {8'(8'h81 + c * 8'h13 + g), 8'(c + g * 16), 8'(8'h5A ^ c ^ (g << 4))};
  endfunction

  function automatic logic [23:0] exp_val(int a);
    if (a < 6)  return ch_val[a];
    if (a < 11) return ctl[a - 6];
    return 24'h0;
  endfunction

  task automatic check(bit ok, string req, logic [23:0] act, logic [23:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic push_dr(int g);
    @(negedge clk);
    for (int c = 0; c < 6; c++) begin
      ch_val[c] = gen_val(c, g);
      dr_data[c*24 +: 24] = ch_val[c];
    end
    dr_strobe = 1'b1;
    @(negedge clk);
    dr_strobe = 1'b0;
  endtask

  task automatic start_tx(int a, bit w);
    @(negedge clk);
    hst_start = 1'b1; hst_addr = 5'(a); hst_rw = w;
    @(negedge clk);
    hst_start = 1'b0;
  endtask

  task automatic stop_tx();
    @(negedge clk);
    hst_stop = 1'b1;
    @(negedge clk);
    hst_stop = 1'b0;
  endtask

  task automatic byte_op(input logic [7:0] wd, output logic [7:0] rd);
    hst_byte_req = 1'b1; hst_wdata = wd;
    @(negedge clk);
    hst_byte_req = 1'b0;
    rd = hst_rdata;
  endtask

  task automatic read_word(output logic [23:0] w);
    logic [7:0] b;
    for (int i = 0; i < 3; i++) begin
      byte_op(8'h00, b);
      w = {w[15:0], b};
    end
  endtask

  task automatic write_reg(int a, logic [23:0] w);
    logic [7:0] b;
    start_tx(a, 1'b1);
    byte_op(w[23:16], b);
    byte_op(w[15:8], b);
    byte_op(w[7:0], b);
    stop_tx();
    if (a >= 6 && a <= 10) ctl[a - 6] = w;
  endtask

  task automatic set_mode(logic [1:0] m);
    write_reg(9, {m, 22'h15A5A});
  endtask

  initial begin
    logic [23:0] w, oldw;
    logic [7:0]  b0, b1, b2, keep;
    for (int c = 0; c < 6; c++) ch_val[c] = '0;
    for (int k = 0; k < 5; k++) ctl[k] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    check(hst_rdata == 8'h00, "R1 reset rdata", {16'h0, hst_rdata}, 24'h0);
    start_tx(7, 1'b0);
    read_word(w);
    stop_tx();
    check(w == 24'h0, "R1 control word reset", w, 24'h0);

    push_dr(1);  // R2
    start_tx(4, 1'b0);
    read_word(w);
    stop_tx();
    check(w == ch_val[4], "R2 result loaded", w, ch_val[4]);

    // R1 and R6: control write and read-back
    write_reg(7, 24'hC0FFEE);
    write_reg(10, 24'h123456);
    start_tx(7, 1'b0);
    read_word(w);
    stop_tx();
    check(w == 24'hC0FFEE, "R6 write readback", w, 24'hC0FFEE);

    // Vector walk: loop orders R8..R11, unmapped R7
    for (int v = 0; v < 8; v++) begin
      logic [1:0] m;
      int a [4];
      m = VEC[v][21:20];
      a[0] = int'(VEC[v][19:15]); a[1] = int'(VEC[v][14:10]);
      a[2] = int'(VEC[v][9:5]);   a[3] = int'(VEC[v][4:0]);
      set_mode(m);
      start_tx(a[0], 1'b0);
      for (int k = 0; k < 4; k++) begin
        read_word(w);
        check(w == exp_val(a[k]), $sformatf("R%0d loop vec%0d word%0d",
              (m == 2'd0) ? 8 : (a[0] > 10) ? 7 : 8 + int'(m), v, k), w, exp_val(a[k]));
      end
      stop_tx();
    end

    // R6: writes to results and unmapped addresses are ignored
    set_mode(2'd0);
    write_reg(2, 24'hFFFFFF);
    start_tx(2, 1'b0);
    read_word(w);
    stop_tx();
    check(w == ch_val[2], "R6 result write ignored", w, ch_val[2]);
    write_reg(13, 24'hABCDEF);
    start_tx(13, 1'b0);
    read_word(w);
    stop_tx();
    check(w == 24'h0, "R7 unmapped read zero", w, 24'h0);
    start_tx(10, 1'b0);
    read_word(w);
    stop_tx();
    check(w == 24'h123456, "R6 control untouched by unmapped write", w, 24'h123456);

    // R3 and R5: strobe between bytes leaves the word whole, MSB first
    start_tx(0, 1'b0);
    oldw = ch_val[0];
    byte_op(8'h00, b0);
    push_dr(2);
    byte_op(8'h00, b1);
    byte_op(8'h00, b2);
    check(b0 == oldw[23:16], "R5 first byte is MSB", {16'h0, b0}, {16'h0, oldw[23:16]});
    check({b0, b1, b2} == oldw, "R3 word not torn", {b0, b1, b2}, oldw);
    read_word(w);
    check(w == ch_val[0], "R3 next read sees new sample", w, ch_val[0]);
    stop_tx();

    // R4: strobe in the same cycle as the first-byte request
    start_tx(3, 1'b0);
    for (int c = 0; c < 6; c++) begin
      ch_val[c] = gen_val(c, 3);
      dr_data[c*24 +: 24] = ch_val[c];
    end
    dr_strobe = 1'b1;
    byte_op(8'h00, b0);
    dr_strobe = 1'b0;
    byte_op(8'h00, b1);
    byte_op(8'h00, b2);
    check({b0, b1, b2} == ch_val[3], "R4 same-cycle bypass", {b0, b1, b2}, ch_val[3]);
    stop_tx();

    // R12: requests outside a transaction are ignored
    keep = hst_rdata;
    for (int i = 0; i < 4; i++) byte_op(8'h77, b0);
    check(hst_rdata == keep, "R12 idle request ignored", {16'h0, hst_rdata}, {16'h0, keep});
    start_tx(8, 1'b1);
    stop_tx();
    for (int i = 0; i < 3; i++) byte_op(8'h99, b0);
    start_tx(8, 1'b0);
    read_word(w);
    stop_tx();
    check(w == ctl[2], "R12 idle write bytes ignored", w, ctl[2]);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule